// File: doc/BRIEF.md
# Dithered Two-Phase PWM Generator

This block drives a single pulse-width-modulated output from an 8-bit duty value. It does not use one 256-clock ramp. Each full period is split into two back-to-back phases of 128 clocks.

- The seven upper bits of the duty value set a base high time that is used in both phases.
- The lowest bit adds one extra high clock in phase 0 only.
- The carrier therefore runs at the clock divided by 128, while the average duty keeps the full 8-bit resolution of value/256.

The duty input is captured once per full period, at its first clock. A period is never built from two different duty values. While the enable input is low, the output stays low and both counters are held at zero. When enable returns, a new period starts at once. A one-clock strobe marks the first clock of every period.

Top module: `dpwm_gen`

## Requirements
- R1: While `en` is low (including right after reset), `pwm_out` and `cyc_start` are both 0.
- R2: With `en` held high, `cyc_start` pulses exactly once every 256 clocks, and each phase lasts 128 clocks.
- R3: In phase 0 the output is high for (duty[7:1] + duty[0]) clocks. With duty = 255, this means the whole phase is high.
- R4: In phase 1 the output is high for duty[7:1] clocks. A value of 0 there gives a phase that is low throughout.
- R5: Within a phase, the high clocks come first, starting at the phase's first clock, followed by a single low stretch that lasts until the phase ends.
- R6: The duty input is captured only at the first clock of a period. A change during a period takes effect from the next period.
- R7: When `en` goes from low to high, the first clock with `en` high is clock 0 of phase 0 of a new period.
- R8: `cyc_start` is a single-clock pulse. It is high only on clock 0 of phase 0.
- R9: Over one full period, the number of high clocks equals the duty value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the PWM |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the output low and clears the counters |
| duty | input | 8 | Duty value: bits 7..1 give the base high time, bit 0 gives the dither |
| pwm_out | output | 1 | PWM output |
| cyc_start | output | 1 | One-clock strobe on the first clock of each full period |

## Verification
The assertions assume that `duty` is stable around each clock edge. They also assume that `en` changes only between edges, so that the duty value captured at an edge is the same value that set the output on that clock.

The bench changes `duty` and `en` only on falling edges and samples outputs one time unit later. This keeps every capture unambiguous. Mid-period duty changes are placed well inside a phase, so the capture rule is tested without racing the edge.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // High clocks in a phase: base, plus one in phase 0 when dither is set.
  function automatic int unsigned high_clocks(int unsigned base, bit dith, bit phase);
    return base + ((dith && !phase) ? 1 : 0);
  endfunction

  // True while the running count is inside the high part of a phase.
  function automatic bit in_high(int unsigned count, int unsigned hi);
    return count < hi;
  endfunction

endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int SUB_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  output logic [SUB_BITS-1:0] cnt,
  output logic                phase,
  output logic                at_start
);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (&cnt) phase <= ~phase;
    end
  end

  assign at_start = (cnt == '0) && !phase;

endmodule

// File: rtl/dpwm_duty_hold.sv
module dpwm_duty_hold #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [DUTY_W-1:0] duty_q,
  output logic [DUTY_W-1:0] duty_eff
);

  always_ff @(posedge clk) begin
    if (!rst_n)    duty_q <= '0;
    else if (load) duty_q <= duty_in;
  end

  // On the first clock of a period the fresh input already applies.
  assign duty_eff = load ? duty_in : duty_q;

endmodule

// File: rtl/dpwm_shape.sv
module dpwm_shape #(
  parameter int SUB_BITS = 7
) (
  input  logic                en,
  input  logic [SUB_BITS-1:0] cnt,
  input  logic                phase,
  input  logic [SUB_BITS:0]   duty_eff,
  output logic [SUB_BITS:0]   hi_clocks,
  output logic                pwm
);

  logic [SUB_BITS-1:0] base;
  logic                dith;

  assign base = duty_eff[SUB_BITS:1];
  assign dith = duty_eff[0];

  always_comb begin
    hi_clocks = (SUB_BITS+1)'(dpwm_pkg::high_clocks(int'(base), dith, phase));
    pwm       = en && dpwm_pkg::in_high(int'(cnt), int'(hi_clocks));
  end

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
  parameter int SUB_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SUB_BITS:0]   duty,
  output logic                pwm_out,
  output logic                cyc_start
);

  localparam int DUTY_W = SUB_BITS + 1;

  logic [SUB_BITS-1:0] cnt_w;
  logic                phase_w;
  logic                at_start_w;
  logic                load_w;
  logic [DUTY_W-1:0]   duty_q_w;
  logic [DUTY_W-1:0]   duty_eff_w;
  logic [SUB_BITS:0]   hi_w;

  dpwm_counter #(.SUB_BITS(SUB_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cnt(cnt_w), .phase(phase_w), .at_start(at_start_w)
  );

  assign load_w    = en && at_start_w;
  assign cyc_start = load_w;

  dpwm_duty_hold #(.DUTY_W(DUTY_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load_w), .duty_in(duty),
    .duty_q(duty_q_w), .duty_eff(duty_eff_w)
  );

  dpwm_shape #(.SUB_BITS(SUB_BITS)) u_shape (
    .en(en), .cnt(cnt_w), .phase(phase_w), .duty_eff(duty_eff_w),
    .hi_clocks(hi_w), .pwm(pwm_out)
  );

endmodule

// File: rtl/dpwm_gen_chk.sv
module dpwm_gen_chk #(
  parameter int SUB_BITS = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                pwm_out,
  input logic                cyc_start,
  input logic [SUB_BITS-1:0] cnt,
  input logic                phase,
  input logic [SUB_BITS:0]   duty_q
);

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pwm_out && !cyc_start)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(&cnt)) |=> (!en || (cnt == $past(cnt) + SUB_BITS'(1) && phase == $past(phase)))); // R2

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (&cnt)) |=> (!en || (cnt == '0 && phase != $past(phase)))); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start); // R8

  AST_LOW_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pwm_out && !(&cnt)) |=> (!en || !pwm_out)); // R5

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(duty_q)); // R6

  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (en -> cyc_start)); // R7

endmodule

bind dpwm_gen dpwm_gen_chk #(.SUB_BITS(SUB_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_out(pwm_out), .cyc_start(cyc_start),
  .cnt(cnt_w), .phase(phase_w), .duty_q(duty_q_w)
);

// File: tb/dpwm_gen_bench.sv
module dpwm_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] duty = 8'd0;
  logic       pwm_out;
  logic       cyc_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dpwm_gen u_dpwm_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .duty(duty),
    .pwm_out(pwm_out), .cyc_start(cyc_start)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // High time the requirements give for a phase, restated independently.
  function automatic int exp_hi(input int d, input int ph);
    int h;
    h = d / 2;
    if (ph == 0 && (d % 2) == 1) h = h + 1;
    return h;
  endfunction

  // Advance one clock, ending just after the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Samples one full period. The state is assumed to be clock 0 of phase 0.
  // At sample chg_at the duty input is changed to new_val.
  task automatic run_period(input int exp_d, input int chg_at, input int new_val, input string req);
    int highs = 0;
    for (int k = 0; k < 256; k++) begin
      if (k == chg_at) duty = 8'(new_val);
      #1;
      chk(req, $sformatf("pwm k=%0d", k), int'(pwm_out),
          int'((k % 128) < exp_hi(exp_d, k / 128)));
      chk("R8", $sformatf("strobe k=%0d", k), int'(cyc_start), int'(k == 0));
      if (pwm_out) highs++;
      step();
    end
    chk("R9", "high clocks per period", highs, exp_d);
  endtask

  task automatic restart(input int d);
    en = 1'b0;
    step();
    duty = 8'(d);
    en = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "pwm in reset", int'(pwm_out), 0);
    chk("R1", "strobe in reset", int'(cyc_start), 0);
    step();
    rst_n = 1'b1;
    step();
    #1;
    chk("R1", "pwm idle after reset", int'(pwm_out), 0);
    chk("R1", "strobe idle after reset", int'(cyc_start), 0);
  endtask

  task automatic t_patterns();
    int vals[6] = '{8'd0, 8'd1, 8'd2, 8'd127, 8'd200, 8'd255};
    foreach (vals[i]) begin
      restart(vals[i]);
      run_period(vals[i], -1, 0, (vals[i] % 2) ? "R3" : "R4");
    end
  endtask

  task automatic t_back_to_back();
    restart(8'd77);
    run_period(77, -1, 0, "R2");
    run_period(77, -1, 0, "R5");
  endtask

  task automatic t_mid_change();
    restart(8'd30);
    run_period(30, 50, 181, "R6");
    run_period(181, 160, 9, "R6");
    run_period(9, -1, 0, "R6");
  endtask

  task automatic t_enable_drop();
    restart(8'd255);
    for (int k = 0; k < 100; k++) step();
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R1", "pwm while disabled", int'(pwm_out), 0);
      chk("R1", "strobe while disabled", int'(cyc_start), 0);
      step();
    end
    duty = 8'd64;
    en = 1'b1;
    run_period(64, -1, 0, "R7");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_patterns();
    t_back_to_back();
    t_mid_change();
    t_enable_drop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule